// File: doc/BRIEF.md
# Round-Robin Dual-Channel ADC Capture Sequencer

This block runs a two-channel pipelined converter whose I and Q results share one 10-bit bus, together with two 4:1 analog selectors in front of it, so that eight analog inputs are scanned in turn. It derives the converter clock from the faster system clock by counting a programmable half period. The selector codes advance once per converter clock. The bus is read at a programmable delay after each clock edge: the I result after the rising edge and the Q result after the falling edge.

The converter returns each result three clocks after it sampled it. The block therefore carries the selector codes through a matching delay line. Each emitted 16-bit word names the input that was really sampled. Words leave on a one-cycle valid strobe, with I ahead of Q. The first pairs after a start hold stale pipeline contents and are suppressed. Dropping `start` parks the clock low, disables the converter and empties the delay line.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, and from the cycle after `start` is seen low, `adcEnN` is 1, `adcClk` is 0 and both selector codes are 0. No word is emitted while `start` stays low.
- R2: `adcEnN` is driven low in the cycle after a system clock edge at which `start` is high.
- R3: While `start` is high, each high phase and each low phase of `adcClk` lasts exactly `halfPeriod` system cycles, except the first low phase after a start. `halfPeriod` must be at least 2.
- R4: `selI` and `selQ` change only in the cycle in which `adcClk` rises, or when the block stops. At each rise both step together through 0, 1, 2, 3, 0. The first sampling edge after a start uses code 0.
- R5: The I word reaches `wordOut` with `wordValid` high `captureDelay`+1 system cycles after the cycle in which `adcClk` rose. `captureDelay` must be below `halfPeriod`.
- R6: The Q word appears `captureDelay`+1 system cycles after the cycle in which `adcClk` fell. `wordValid` is high for a single cycle per word, and the I word of a pair always comes before its Q word.
- R7: Word layout: bits [9:0] carry the bus code unchanged, including 0, 512 and 1023. Bits [12:10] carry the input number: `selI` (0 to 3) for I words and 4 plus `selQ` (4 to 7) for Q words. Bits [15:13] are 0.
- R8: The input number in bits [12:10] is the selector code that was present at the rising edge three converter clocks before the edge that precedes the readout. The pairs read out after the first three rising edges following a start are not emitted.
- R9: Stopping and then restarting resets the selectors to 0 and clears the tag delay line. After the restart, the first three pairs are suppressed again and the tags restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High to run the scan, low to stop |
| halfPeriod | input | 8 | Converter clock half period in system cycles (at least 2) |
| captureDelay | input | 8 | Cycles from a converter clock edge to the bus read (below halfPeriod) |
| adcData | input | 10 | Shared I/Q result bus from the converter |
| adcClk | output | 1 | Converter sample clock |
| adcEnN | output | 1 | Converter enable, active low |
| selI | output | 2 | Selector code for the I-side 4:1 switch |
| selQ | output | 2 | Selector code for the Q-side 4:1 switch |
| wordOut | output | 16 | Tagged sample word |
| wordValid | output | 1 | One-cycle strobe for `wordOut` |

## Verification
The assertions assume three things about the inputs. `halfPeriod` is at least 2. `captureDelay` is below `halfPeriod`. Both stay constant while `start` is high, so that phase lengths are fixed and an I or Q strobe never lands in a cycle right after another. The bench programs only legal pairs, including both extremes of the delay (0 and `halfPeriod`-1). It changes them only while stopped, and it drops `start` only just after a Q word, so that no capture is cut off mid-pair.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic rise;
    logic capI;
    logic capQ;
    logic clear;
  } scanStrobes_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic [CNT_W-1:0] captureDelay,
  output logic             adcClk,
  output logic             adcEnN,
  output logic [SEL_W-1:0] selCode,
  output scanStrobes_t     strb
);
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             phaseEnd;
  logic             atCapture;

  assign lastCnt   = halfPeriod - 1'b1;
  assign phaseEnd  = (phaseCnt >= lastCnt);
  assign atCapture = (phaseCnt == captureDelay);

  always_comb begin
    strb.clear = !start;
    strb.rise  = start && phaseEnd && !adcClk;
    strb.capI  = start && adcClk && atCapture;
    strb.capQ  = start && !adcClk && atCapture;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      adcClk   <= 1'b0;
      adcEnN   <= 1'b1;
      selCode  <= '0;
    end else begin
      adcEnN <= !start;
      if (!start) begin
        phaseCnt <= '0;
        adcClk   <= 1'b0;
        selCode  <= '0;
      end else if (phaseEnd) begin
        phaseCnt <= '0;
        adcClk   <= !adcClk;
        if (!adcClk) selCode <= selCode + 1'b1;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_dpath.sv
module scan_dpath
  import adc_scan_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int SEL_W   = 2,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobes_t      strb,
  input  logic [SEL_W-1:0]  selI,
  input  logic [SEL_W-1:0]  selQ,
  input  logic [DATA_W-1:0] adcData,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int PIPE_D = LATENCY + 1;
  localparam int FILL_W = $clog2(PIPE_D + 1);
  localparam int PAD_W  = WORD_W - DATA_W - SEL_W - 1;
  localparam logic [FILL_W-1:0] FULL = FILL_W'(PIPE_D);

  logic [SEL_W-1:0]  tagI [PIPE_D];
  logic [SEL_W-1:0]  tagQ [PIPE_D];
  logic [FILL_W-1:0] fillCnt;
  logic              primed;

  assign primed = (fillCnt == FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      for (int k = 0; k < PIPE_D; k++) begin
        tagI[k] <= '0;
        tagQ[k] <= '0;
      end
    end else if (strb.clear) begin
      fillCnt <= '0;
      for (int k = 0; k < PIPE_D; k++) begin
        tagI[k] <= '0;
        tagQ[k] <= '0;
      end
    end else if (strb.rise) begin
      if (!primed) fillCnt <= fillCnt + 1'b1;
      tagI[0] <= selI;
      tagQ[0] <= selQ;
      for (int k = 1; k < PIPE_D; k++) begin
        tagI[k] <= tagI[k-1];
        tagQ[k] <= tagQ[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (primed && strb.capI) begin
        wordOut   <= {{PAD_W{1'b0}}, 1'b0, tagI[LATENCY], adcData};
        wordValid <= 1'b1;
      end else if (primed && strb.capQ) begin
        wordOut   <= {{PAD_W{1'b0}}, 1'b1, tagQ[LATENCY], adcData};
        wordValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 10,
  parameter int SEL_W   = 2,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  halfPeriod,
  input  logic [CNT_W-1:0]  captureDelay,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcClk,
  output logic              adcEnN,
  output logic [SEL_W-1:0]  selI,
  output logic [SEL_W-1:0]  selQ,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  scanStrobes_t     strb;
  logic [SEL_W-1:0] selCode;

  assign selI = selCode;
  assign selQ = selCode;

  scan_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .halfPeriod(halfPeriod), .captureDelay(captureDelay),
    .adcClk(adcClk), .adcEnN(adcEnN), .selCode(selCode), .strb(strb)
  );

  scan_dpath #(.DATA_W(DATA_W), .SEL_W(SEL_W), .LATENCY(LATENCY)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .selI(selI), .selQ(selQ),
    .adcData(adcData), .wordOut(wordOut), .wordValid(wordValid)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             adcClk,
  input logic             adcEnN,
  input logic [SEL_W-1:0] selI,
  input logic [15:0]      wordOut,
  input logic             wordValid
);
  a_r1_stop_parks: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (adcEnN && !adcClk));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !start ##1 !start |=> !wordValid);

  a_r2_enable_low: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !adcEnN);

  a_r3_rise_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcClk) |-> !adcEnN);

  a_r4_sel_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selI) |-> ($rose(adcClk) || adcEnN));

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordOut[15:13] == 3'b000));
endmodule

bind adc_scan_seq adc_scan_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .adcClk(adcClk), .adcEnN(adcEnN),
  .selI(selI), .wordOut(wordOut), .wordValid(wordValid)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  halfPeriod = 8'd4;
  logic [7:0]  captureDelay = 8'd2;
  logic [9:0]  adcData = 10'h155;
  logic        adcClk, adcEnN, wordValid;
  logic [1:0]  selI, selQ;
  logic [15:0] wordOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  adc_scan_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .halfPeriod(halfPeriod),
    .captureDelay(captureDelay), .adcData(adcData), .adcClk(adcClk),
    .adcEnN(adcEnN), .selI(selI), .selQ(selQ), .wordOut(wordOut),
    .wordValid(wordValid)
  );

  always #2 clk = !clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference state
  logic [15:0] expQ [$];
  logic [15:0] latI [$];
  logic [15:0] latQ [$];
  logic [15:0] curQ;
  bit   curQValid = 0;
  bit   prevClk = 0;
  bit   startSeen = 0;
  int   prevSel = 0;
  int   riseIdx = 0;
  int   phaseLen = 0;
  bit   firstPhase = 1;
  int   sinceRise = 0;
  int   sinceFall = 0;
  int   wordsThisRun = 0;
  bit   pairDone = 0;
  bit   running = 0;

  function automatic logic [9:0] codeFor(input int inp, input int idx);
    case (idx % 5)
      0: return 10'd0;
      1: return 10'd1023;
      2: return 10'd512;
      default: return 10'((inp * 97 + idx * 31) % 1024);
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      sinceRise++;
      sinceFall++;
      // R2 / R1: enable follows start of the previous edge
      check(adcEnN == !startSeen, "R2 enable", adcEnN, !startSeen);
      if (!startSeen) begin
        check(adcClk == 0 && selI == 0 && selQ == 0, "R1 idle outputs",
              {adcClk, selI, selQ}, 0);
      end
      // words first (a Q word can share a negedge with a rise)
      if (wordValid) begin
        wordsThisRun++;
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected word", wordOut, -1);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(wordOut == e, "R7 word content", wordOut, e);
          if (e[12] == 1'b0)
            check(sinceRise == captureDelay + 1, "R5 I timing", sinceRise, captureDelay + 1);
          else begin
            check(sinceFall == captureDelay + 1, "R6 Q timing", sinceFall, captureDelay + 1);
            if (expQ.size() == 0) pairDone = 1;
          end
        end
      end
      // clock phase lengths (R3)
      if (adcClk == prevClk) phaseLen++;
      else begin
        if (!adcEnN && !firstPhase)
          check(phaseLen == halfPeriod, "R3 phase length", phaseLen, halfPeriod);
        firstPhase = 0;
        phaseLen = 1;
      end
      // selector behaviour (R4)
      if (!(adcClk && !prevClk) && !adcEnN)
        check(selI == prevSel, "R4 selector steady", selI, prevSel);
      if (adcClk && !prevClk) begin
        riseIdx++;
        sinceRise = 0;
        if (riseIdx == 1) check(prevSel == 0, "R4 first code", prevSel, 0);
        check(selI == (prevSel + 1) % 4 && selQ == selI, "R4 step", selI, (prevSel + 1) % 4);
        if (riseIdx == 4) check(wordsThisRun == 0, "R8 discard first pairs", wordsThisRun, 0);
        latI.push_back({3'b000, 1'b0, 2'(prevSel), codeFor(prevSel, riseIdx)});
        latQ.push_back({3'b000, 1'b1, 2'(prevSel), codeFor(4 + prevSel, riseIdx)});
        if (latI.size() > 3) begin
          logic [15:0] wI;
          wI = latI.pop_front();
          curQ = latQ.pop_front();
          curQValid = 1;
          adcData = wI[9:0];
          expQ.push_back(wI);
          expQ.push_back(curQ);
        end else begin
          curQValid = 0;
          adcData = 10'h155;
        end
      end else if (!adcClk && prevClk) begin
        sinceFall = 0;
        adcData = curQValid ? curQ[9:0] : 10'h2AA;
      end
      prevClk = adcClk;
      prevSel = selI;
    end
    startSeen = start;
  end

  task automatic runConfig(input int hp, input int dly);
    halfPeriod = 8'(hp);
    captureDelay = 8'(dly);
    expQ.delete(); latI.delete(); latQ.delete();
    riseIdx = 0; firstPhase = 1; wordsThisRun = 0; pairDone = 0; curQValid = 0;
    @(posedge clk); #1 start = 1'b1;
    forever begin
      @(posedge clk);
      if (pairDone && riseIdx >= 12) break;
      pairDone = 0;
    end
    #1 start = 1'b0;
    // R9: parked and quiet after stop
    repeat (3) @(negedge clk);
    expQ.delete(); latI.delete(); latQ.delete();
    repeat (6) @(negedge clk);
    check(adcEnN == 1 && adcClk == 0 && selI == 0 && wordValid == 0,
          "R9 stopped state", {adcEnN, adcClk, selI, wordValid}, 8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #0;
    check(adcEnN == 1 && adcClk == 0 && wordValid == 0 && selI == 0 && selQ == 0,
          "R1 reset state", {adcEnN, adcClk, wordValid, selI, selQ}, 8'h20);
    runConfig(4, 2);
    runConfig(2, 1);
    runConfig(6, 5);
    runConfig(3, 0);
    runConfig(4, 3);
    check(checks > 12, "R9 run count", checks, 13);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule